// File: doc/BRIEF.md
# Configuration Retry and Mode Controller

This block sits next to the configuration-request handler of a PCIe endpoint whose programmable fabric may not be loaded yet when the link comes up. It decides, for each incoming request, whether the request gets a normal answer, a configuration retry status, or is routed to the fabric-programming path. It drives the fabric-programming enable and raises a fault flag when the fabric stays unready past the retry window. It also holds the endpoint core in reset while the fundamental reset is low.

Its behaviour depends on two strap bits. The first enables loading the fabric over the link. The second says whether the whole device was loaded by a standard method. When programming over the link is off, or the fabric was fully loaded but is not yet in user mode, configuration requests get retry status until user mode arrives. When only the link core and I/O were loaded, the block enters programming mode once the link reaches L0. After the programming engine reports completion, control passes to the application. If programming is enabled, a host control write can later switch the block back to programming mode.

Requests arrive as a valid/ready stream, and each request yields one response beat. The controller holds at most one response. A request is accepted (`req_ready` high) only when the controller is in a post-L0 phase and the response slot is empty, or is being drained in that same cycle. A response stays valid with a constant code until `resp_ready` is high at a clock edge.

Top module: `cfg_retry_ctrl`

## Requirements
- R1: While `fund_rst_n` is low, `core_rst_n`, `resp_valid`, `fabric_prog_en` and `retry_fault` are all 0. `core_rst_n` rises one clock after reset release, provided `core_cold_rst` is low.
- R2: Before the link reports L0, no request is accepted (`req_ready`=0) and `fabric_prog_en` stays 0.
- R3: In the retry phase, a configuration request (`req_is_cfg`=1) is answered with code 01 (retry) and any other request with code 00 (normal).
- R4: The retry window opens at the first accepted configuration request answered with retry. It lasts `WINDOW_MS`×`CYC_PER_MS` cycles. If the block is still in the retry phase when the window ends, `retry_fault` rises one cycle later and stays high until the fundamental reset.
- R5: With straps (programming-enabled=0, full-init=1), the fabric is never programmed over the link. A `host_switch_req` pulse in the application phase is ignored.
- R6: With straps (1,0) and the fabric not in user mode, reaching L0 enters programming mode. `fabric_prog_en` is 1 and every request is answered with code 10 (route to programming).
- R7: In programming mode, a `prog_done` pulse hands over to the application phase. `fabric_prog_en` drops and all requests get code 00.
- R8: When programming over the link is enabled, a `host_switch_req` pulse in the application phase re-enters programming mode.
- R9: With straps (1,1) and the fabric not in user mode, configuration requests get retry status. Once `fabric_user` is 1, requests get code 00 and no fault is raised.
- R10: While `core_cold_rst` is high, `core_rst_n` is 0 and no request is accepted. After the cold reset, if the fabric is in user mode, the block returns to the application phase without starting a load.
- R11: Straps (0,0) behave exactly like (0,1).
- R12: A response held with `resp_ready` low keeps `resp_valid` high and `resp_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| core_cold_rst | input | 1 | Cold reset of the link core, active high |
| link_up | input | 1 | Link has reached L0 |
| fabric_user | input | 1 | Fabric is loaded and in user mode |
| strap_prog_en | input | 1 | Strap: fabric programming over the link enabled |
| strap_full_init | input | 1 | Strap: whole device loaded by a standard method |
| prog_done | input | 1 | Programming engine reports completion (pulse) |
| host_switch_req | input | 1 | Host control write requesting programming mode (pulse) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_is_cfg | input | 1 | Request is a configuration request |
| resp_valid | output | 1 | Response select valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_sel | output | 2 | 00 normal, 01 retry status, 10 route to programming |
| core_rst_n | output | 1 | Reset to the endpoint core, active low |
| fabric_prog_en | output | 1 | Fabric programming enabled |
| retry_fault | output | 1 | Retry window expired with the fabric unready |

## Verification
The bench builds the block with `CYC_PER_MS`=10 and `WINDOW_MS`=5, so the fault window closes 50 cycles after the first retry answer. This brings both the expiry and the early-exit case into a short run. The defaults describe a one-second window at 125 MHz, far beyond any simulation. With the small values, the exact expiry cycle is bracketed, and so are the sticky fault, all four strap combinations, the host switch-back and the cold-reset return.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
  typedef enum logic [1:0] {
    CR_WAIT  = 2'd0,
    CR_RETRY = 2'd1,
    CR_PROG  = 2'd2,
    CR_APP   = 2'd3
  } cr_state_e;

  typedef enum logic [1:0] {
    RSP_NORMAL = 2'b00,
    RSP_RETRY  = 2'b01,
    RSP_PROG   = 2'b10
  } rsp_sel_e;
endpackage

// File: rtl/cfg_retry_window.sv
module cfg_retry_window #(
  parameter int CYC_PER_MS = 125000,
  parameter int WINDOW_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic expired
);
  localparam int PW = $clog2(CYC_PER_MS > 1 ? CYC_PER_MS : 2);
  localparam int MW = $clog2(WINDOW_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(WINDOW_MS);

  logic          running;
  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] ms_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (clear) begin
      running <= 1'b0;
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else begin
      if (start) running <= 1'b1;
      if (running && ms_cnt != MS_LAST) begin
        if (pre_cnt == PRE_LAST) begin
          pre_cnt <= '0;
          ms_cnt  <= ms_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  assign expired = running && (ms_cnt == MS_LAST);

  p_ms_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt <= MS_LAST);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start && !clear) |=> (ms_cnt == '0 && pre_cnt == '0));
endmodule

// File: rtl/cfg_retry_fsm.sv
module cfg_retry_fsm
  import cfg_retry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_ok,
  input  logic      fabric_user,
  input  logic      strap_prog_en,
  input  logic      strap_full_init,
  input  logic      prog_done,
  input  logic      host_switch_req,
  input  logic      expired,
  output cr_state_e state,
  output logic      fault
);
  cr_state_e nxt;

  always_comb begin
    nxt = state;
    if (!link_ok) begin
      nxt = CR_WAIT;
    end else begin
      unique case (state)
        CR_WAIT: begin
          if (fabric_user)                          nxt = CR_APP;
          else if (strap_prog_en && !strap_full_init) nxt = CR_PROG;
          else                                      nxt = CR_RETRY;
        end
        CR_RETRY: if (fabric_user)                      nxt = CR_APP;
        CR_PROG:  if (prog_done)                        nxt = CR_APP;
        CR_APP:   if (host_switch_req && strap_prog_en) nxt = CR_PROG;
        default:  nxt = CR_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CR_WAIT;
      fault <= 1'b0;
    end else begin
      state <= nxt;
      if (state == CR_RETRY && expired) fault <= 1'b1;
    end
  end

  p_prog_after_l0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CR_PROG && $past(state) == CR_WAIT) |-> $past(link_ok));
  p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_no_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CR_APP && !strap_prog_en) |=> state != CR_PROG);
  p_done_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CR_PROG && prog_done && link_ok) |=> state == CR_APP);
  p_switch_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CR_APP && host_switch_req && strap_prog_en && link_ok) |=> state == CR_PROG);
endmodule

// File: rtl/cfg_retry_resp.sv
module cfg_retry_resp
  import cfg_retry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cr_state_e  state,
  input  logic       req_valid,
  input  logic       req_is_cfg,
  output logic       req_ready,
  output logic       resp_valid,
  input  logic       resp_ready,
  output logic [1:0] resp_sel,
  output logic       retry_hs
);
  logic     accept;
  rsp_sel_e code;

  assign req_ready = (state != CR_WAIT) && (!resp_valid || resp_ready);
  assign accept    = req_valid && req_ready;

  always_comb begin
    unique case (state)
      CR_RETRY: code = req_is_cfg ? RSP_RETRY : RSP_NORMAL;
      CR_PROG:  code = RSP_PROG;
      default:  code = RSP_NORMAL;
    endcase
  end

  assign retry_hs = accept && (state == CR_RETRY) && req_is_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_sel   <= RSP_NORMAL;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_sel   <= code;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_sel)));
  p_prog_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == CR_PROG) |=> resp_sel == RSP_PROG);
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
  import cfg_retry_pkg::*;
#(
  parameter int CYC_PER_MS = 125000,
  parameter int WINDOW_MS  = 1000
) (
  input  logic       clk,
  input  logic       fund_rst_n,
  input  logic       core_cold_rst,
  input  logic       link_up,
  input  logic       fabric_user,
  input  logic       strap_prog_en,
  input  logic       strap_full_init,
  input  logic       prog_done,
  input  logic       host_switch_req,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_cfg,
  output logic       resp_valid,
  input  logic       resp_ready,
  output logic [1:0] resp_sel,
  output logic       core_rst_n,
  output logic       fabric_prog_en,
  output logic       retry_fault
);
  cr_state_e state;
  logic      link_ok;
  logic      retry_hs;
  logic      expired;

  assign link_ok = link_up && !core_cold_rst;

  always_ff @(posedge clk or negedge fund_rst_n) begin
    if (!fund_rst_n) core_rst_n <= 1'b0;
    else             core_rst_n <= !core_cold_rst;
  end

  cfg_retry_fsm u_fsm (
    .clk             (clk),
    .rst_n           (fund_rst_n),
    .link_ok         (link_ok),
    .fabric_user     (fabric_user),
    .strap_prog_en   (strap_prog_en),
    .strap_full_init (strap_full_init),
    .prog_done       (prog_done),
    .host_switch_req (host_switch_req),
    .expired         (expired),
    .state           (state),
    .fault           (retry_fault)
  );

  cfg_retry_window #(
    .CYC_PER_MS (CYC_PER_MS),
    .WINDOW_MS  (WINDOW_MS)
  ) u_window (
    .clk     (clk),
    .rst_n   (fund_rst_n),
    .clear   (state != CR_RETRY),
    .start   (retry_hs),
    .expired (expired)
  );

  cfg_retry_resp u_resp (
    .clk        (clk),
    .rst_n      (fund_rst_n),
    .state      (state),
    .req_valid  (req_valid),
    .req_is_cfg (req_is_cfg),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_sel   (resp_sel),
    .retry_hs   (retry_hs)
  );

  assign fabric_prog_en = (state == CR_PROG) && link_ok;

  p_cold_hold_r10: assert property (@(posedge clk) disable iff (!fund_rst_n)
    core_cold_rst |=> !core_rst_n);
  p_no_accept_cold_r10: assert property (@(posedge clk) disable iff (!fund_rst_n)
    $past(core_cold_rst) |-> !req_ready);
  p_full_no_prog_r5: assert property (@(posedge clk) disable iff (!fund_rst_n)
    !strap_prog_en |-> !fabric_prog_en);
endmodule

// File: tb/cfg_retry_ctrl_test.sv
module cfg_retry_ctrl_test;
  localparam int CPM = 10;
  localparam int WMS = 5;

  logic clk = 1'b0;
  logic fund_rst_n = 1'b0, core_cold_rst = 1'b0, link_up = 1'b0, fabric_user = 1'b0;
  logic strap_prog_en = 1'b0, strap_full_init = 1'b0, prog_done = 1'b0, host_switch_req = 1'b0;
  logic req_valid = 1'b0, req_is_cfg = 1'b0, resp_ready = 1'b0;
  logic req_ready, resp_valid, core_rst_n, fabric_prog_en, retry_fault;
  logic [1:0] resp_sel;

  int checks = 0, fails = 0, cyc = 0, hs_cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_retry_ctrl #(.CYC_PER_MS(CPM), .WINDOW_MS(WMS)) uut (
    .clk(clk), .fund_rst_n(fund_rst_n), .core_cold_rst(core_cold_rst), .link_up(link_up),
    .fabric_user(fabric_user), .strap_prog_en(strap_prog_en), .strap_full_init(strap_full_init),
    .prog_done(prog_done), .host_switch_req(host_switch_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_is_cfg(req_is_cfg), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_sel(resp_sel), .core_rst_n(core_rst_n),
    .fabric_prog_en(fabric_prog_en), .retry_fault(retry_fault));

  // phase codes: 1 retry, 2 programming, 3 application
  function automatic int phase_at_l0(bit pe, bit fi, bit usr);
    if (usr) return 3;
    if (pe && !fi) return 2;
    return 1;
  endfunction

  function automatic int exp_sel(int phase, bit is_cfg);
    if (phase == 1) return is_cfg ? 1 : 0;
    if (phase == 2) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(bit pe, bit fi);
    @(negedge clk);
    fund_rst_n = 1'b0; link_up = 1'b0; fabric_user = 1'b0; core_cold_rst = 1'b0;
    strap_prog_en = pe; strap_full_init = fi; req_valid = 1'b0; resp_ready = 1'b0;
    repeat (3) @(negedge clk);
    fund_rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(bit is_cfg, int expv, string tag);
    bit hs;
    int d;
    @(negedge clk);
    req_valid = 1'b1; req_is_cfg = is_cfg;
    forever begin
      hs = req_ready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    hs_cyc = cyc;
    check(resp_valid && resp_sel == 2'(expv), tag, int'(resp_sel), expv);
    d = $urandom % 4;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      check(resp_valid && resp_sel == 2'(expv), "R12", int'(resp_sel), expv);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic burst(int phase, int n, string tag);
    for (int i = 0; i < n; i++) begin
      bit c = 1'($urandom % 2);
      send(c, exp_sel(phase, c), tag);
    end
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    // straps (1,0): link core and I/O only
    @(negedge clk);
    strap_prog_en = 1'b1; strap_full_init = 1'b0;
    @(negedge clk);
    check(!core_rst_n && !resp_valid && !fabric_prog_en && !retry_fault, "R1",
          int'(core_rst_n), 0);
    fund_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(core_rst_n, "R1", int'(core_rst_n), 1);
    repeat (3) @(negedge clk);
    check(!req_ready && !fabric_prog_en, "R2", int'(req_ready), 0);

    link_up = 1'b1;
    repeat (2) @(negedge clk);
    check(fabric_prog_en, "R6", int'(fabric_prog_en), 1);
    burst(phase_at_l0(1, 0, 0), 8, "R6");

    pulse(prog_done);
    fabric_user = 1'b1;
    check(!fabric_prog_en, "R7", int'(fabric_prog_en), 0);
    burst(3, 8, "R7");

    pulse(host_switch_req);
    check(fabric_prog_en, "R8", int'(fabric_prog_en), 1);
    burst(2, 4, "R8");
    pulse(prog_done);

    // cold reset of link core
    @(negedge clk); core_cold_rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!core_rst_n && !req_ready, "R10", int'(core_rst_n), 0);
    core_cold_rst = 1'b0;
    repeat (3) @(negedge clk);
    check(core_rst_n && !fabric_prog_en, "R10", int'(fabric_prog_en), 0);
    burst(3, 4, "R10");

    // straps (0,1): retry window expiry
    do_reset(1'b0, 1'b1);
    link_up = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b1, 1, "R3");
    wait_cyc(hs_cyc + CPM * WMS - 1);
    check(!retry_fault, "R4", int'(retry_fault), 0);
    wait_cyc(hs_cyc + CPM * WMS + 3);
    check(retry_fault, "R4", int'(retry_fault), 1);
    send(1'b1, 1, "R3");
    send(1'b0, 0, "R3");
    burst(1, 6, "R3");
    fabric_user = 1'b1;
    repeat (3) @(negedge clk);
    check(retry_fault, "R4", int'(retry_fault), 1);
    pulse(host_switch_req);
    check(!fabric_prog_en, "R5", int'(fabric_prog_en), 0);
    burst(3, 4, "R5");

    // straps (0,0)
    do_reset(1'b0, 1'b0);
    link_up = 1'b1;
    repeat (2) @(negedge clk);
    check(!fabric_prog_en, "R11", int'(fabric_prog_en), 0);
    burst(phase_at_l0(0, 0, 0), 8, "R11");

    // straps (1,1)
    do_reset(1'b1, 1'b1);
    link_up = 1'b1;
    repeat (2) @(negedge clk);
    check(!fabric_prog_en, "R9", int'(fabric_prog_en), 0);
    send(1'b1, 1, "R9");
    burst(phase_at_l0(1, 1, 0), 4, "R9");
    fabric_user = 1'b1;
    repeat (80) @(negedge clk);
    check(!retry_fault, "R9", int'(retry_fault), 0);
    burst(3, 6, "R9");
    pulse(host_switch_req);
    check(fabric_prog_en, "R8", int'(fabric_prog_en), 1);
    burst(2, 4, "R8");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule